// File: doc/BRIEF.md
# Ring Node Forwarding Decision Unit

This block sits in every node of a one-way packet ring. Packet descriptors come in from the upstream node. For each one, the block decides whether to hand it to the local output port, pass it on downstream, do both, or drop it. An untagged descriptor for a foreign source asks the node's address table whether the destination belongs to this port. A hit ends the packet's trip at this node. A miss sends the descriptor on unchanged.

An unknown destination therefore goes once around the ring with no tag, and every node looks it up. When it reaches its originating node again, that node marks it as broadcast and sends it round a second time. On this pass every other node delivers a copy and also passes it on. When the broadcast copy comes home it is discarded, so no descriptor circulates forever. The address table and payload movement are outside the block. The block only issues a lookup key and takes back a hit bit one cycle later.

Each descriptor holds a destination address, an opaque payload handle, the ID of the node that put it on the ring, and a broadcast tag. Both ring-facing sides use valid/ready handshakes. A stalled output holds the decision, and the block accepts new descriptors until both of its internal stages are full.

Top module: `ring_fwd_unit`

## Requirements
- R1: A broadcast-tagged descriptor (in_bcast=1) whose source differs from NODE_ID is delivered locally and forwarded with every field unchanged, tag still 1.
- R2: A lookup request with key equal to the descriptor's destination is issued exactly once for an untagged descriptor from a foreign source, and never for any other descriptor.
- R3: An untagged foreign descriptor whose lookup returns lkp_hit=1 is delivered locally and not forwarded.
- R4: An untagged foreign descriptor whose lookup returns lkp_hit=0 is forwarded with all fields unchanged (tag 0) and not delivered.
- R5: An untagged descriptor whose source equals NODE_ID is forwarded with out_bcast=1 and other fields unchanged, and it is not delivered.
- R6: A broadcast-tagged descriptor whose source equals NODE_ID is neither delivered nor forwarded.
- R7: A descriptor accepted at clock edge T appears on the output or deliver strobe in the cycle after edge T+1 and not earlier. The table answers on lkp_hit in the cycle after the request.
- R8: While out_valid=1 and out_ready=0, the output descriptor holds stable and deliver_valid stays low. in_ready drops only when such a stall fills both stages, and descriptors leave in arrival order.
- R9: After reset, out_valid and deliver_valid are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream descriptor valid |
| in_ready | output | 1 | Block can take a descriptor |
| in_bcast | input | 1 | Broadcast tag of incoming descriptor |
| in_src | input | NODE_W | Originating node ID |
| in_mac | input | MAC_W | Destination address |
| in_handle | input | HANDLE_W | Payload handle |
| out_valid | output | 1 | Descriptor for downstream node valid |
| out_ready | input | 1 | Downstream accepts |
| out_bcast | output | 1 | Broadcast tag sent downstream |
| out_src | output | NODE_W | Originating node ID sent downstream |
| out_mac | output | MAC_W | Destination address sent downstream |
| out_handle | output | HANDLE_W | Payload handle sent downstream |
| deliver_valid | output | 1 | One-cycle strobe: hand this descriptor to the local port |
| deliver_src | output | NODE_W | Originating node of delivered descriptor |
| deliver_mac | output | MAC_W | Destination of delivered descriptor |
| deliver_handle | output | HANDLE_W | Payload handle of delivered descriptor |
| lkp_req_valid | output | 1 | Lookup request strobe |
| lkp_req_mac | output | MAC_W | Lookup key |
| lkp_hit | input | 1 | Table answer, one cycle after request |

## Verification
The decision is tried with all four combinations of tag and home/foreign source. The untagged foreign case is run with keys both present in and absent from the table model. Each combination also changes the expected lookup count, which separates a unit that classifies correctly from one that looks up too often or too rarely. Several sources and addresses sit at the edges (source 0, source 15, home ID 3), so a wrong comparison shows up. A stalled output with a second descriptor queued behind it separates correct holding, back-pressure and ordering from a unit that delivers early or reorders descriptors.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // How a descriptor relates to this node
  typedef enum logic [1:0] {
    K_AWAY_PLAIN = 2'd0,  // foreign source, no tag
    K_AWAY_BCAST = 2'd1,  // foreign source, broadcast tag
    K_HOME_PLAIN = 2'd2,  // came back untagged
    K_HOME_BCAST = 2'd3   // came back tagged
  } arrival_e;

  typedef struct packed {
    logic deliver;
    logic forward;
    logic set_tag;
  } verdict_t;

endpackage

// File: rtl/fwd_slot.sv
module fwd_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drain,
  input  logic [W-1:0] d,
  output logic         valid,
  output logic [W-1:0] q
);

  logic         valid_nx;
  logic [W-1:0] q_nx;

  always_comb begin
    valid_nx = valid;
    q_nx     = q;
    if (load) begin
      valid_nx = 1'b1;
      q_nx     = d;
    end else if (drain) begin
      valid_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      valid <= valid_nx;
      if (load) q <= q_nx;
    end
  end

endmodule

// File: rtl/fwd_classify.sv
module fwd_classify
  import fwd_pkg::*;
#(
  parameter int NODE_W  = 4,
  parameter int NODE_ID = 0
) (
  input  logic              tag,
  input  logic [NODE_W-1:0] src,
  output arrival_e          kind
);

  logic home;

  always_comb begin
    home = (src == NODE_W'(NODE_ID));
    case ({home, tag})
      2'b00:   kind = K_AWAY_PLAIN;
      2'b01:   kind = K_AWAY_BCAST;
      2'b10:   kind = K_HOME_PLAIN;
      default: kind = K_HOME_BCAST;
    endcase
  end

endmodule

// File: rtl/fwd_verdict.sv
module fwd_verdict
  import fwd_pkg::*;
(
  input  arrival_e kind,
  input  logic     hit,
  output verdict_t verdict
);

  always_comb begin
    verdict = '0;
    case (kind)
      K_AWAY_PLAIN: begin
        verdict.deliver = hit;
        verdict.forward = ~hit;
      end
      K_AWAY_BCAST: begin
        verdict.deliver = 1'b1;
        verdict.forward = 1'b1;
      end
      K_HOME_PLAIN: begin
        verdict.forward = 1'b1;
        verdict.set_tag = 1'b1;
      end
      default: verdict = '0;  // tagged copy back home: discard
    endcase
  end

endmodule

// File: rtl/fwd_hit_hold.sv
module fwd_hit_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic hit_in,
  output logic hit_eff
);

  logic fresh_q, fresh_nx;
  logic held_q, held_nx;

  always_comb begin
    fresh_nx = launch;
    held_nx  = fresh_q ? hit_in : held_q;
    hit_eff  = fresh_q ? hit_in : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      fresh_q <= fresh_nx;
      held_q  <= held_nx;
    end
  end

endmodule

// File: rtl/ring_fwd_unit.sv
module ring_fwd_unit
  import fwd_pkg::*;
#(
  parameter int MAC_W    = 48,
  parameter int NODE_W   = 4,
  parameter int HANDLE_W = 8,
  parameter int NODE_ID  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_bcast,
  input  logic [NODE_W-1:0]   in_src,
  input  logic [MAC_W-1:0]    in_mac,
  input  logic [HANDLE_W-1:0] in_handle,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_bcast,
  output logic [NODE_W-1:0]   out_src,
  output logic [MAC_W-1:0]    out_mac,
  output logic [HANDLE_W-1:0] out_handle,
  output logic                deliver_valid,
  output logic [NODE_W-1:0]   deliver_src,
  output logic [MAC_W-1:0]    deliver_mac,
  output logic [HANDLE_W-1:0] deliver_handle,
  output logic                lkp_req_valid,
  output logic [MAC_W-1:0]    lkp_req_mac,
  input  logic                lkp_hit
);

  localparam int DW     = 1 + NODE_W + HANDLE_W + MAC_W;
  localparam int HDL_LO = MAC_W;
  localparam int SRC_LO = MAC_W + HANDLE_W;
  localparam int TAG_B  = DW - 1;

  logic [DW-1:0] in_word, a_q, b_q;
  logic          a_valid, b_valid;
  logic          in_take, a_to_b, b_retire, b_free;
  logic          b_hit;
  arrival_e      a_kind, b_kind;
  verdict_t      b_verdict;

  assign in_word = {in_bcast, in_src, in_handle, in_mac};

  // Stage A: accepted descriptor, lookup launched when it moves on
  fwd_slot #(.W(DW)) u_stage_a (
    .clk(clk), .rst_n(rst_n), .load(in_take), .drain(a_to_b),
    .d(in_word), .valid(a_valid), .q(a_q)
  );

  // Stage B: descriptor waiting for its table answer and output slot
  fwd_slot #(.W(DW)) u_stage_b (
    .clk(clk), .rst_n(rst_n), .load(a_to_b), .drain(b_retire),
    .d(a_q), .valid(b_valid), .q(b_q)
  );

  fwd_classify #(.NODE_W(NODE_W), .NODE_ID(NODE_ID)) u_class_a (
    .tag(a_q[TAG_B]), .src(a_q[SRC_LO +: NODE_W]), .kind(a_kind)
  );

  fwd_classify #(.NODE_W(NODE_W), .NODE_ID(NODE_ID)) u_class_b (
    .tag(b_q[TAG_B]), .src(b_q[SRC_LO +: NODE_W]), .kind(b_kind)
  );

  fwd_hit_hold u_hit (
    .clk(clk), .rst_n(rst_n), .launch(a_to_b), .hit_in(lkp_hit), .hit_eff(b_hit)
  );

  fwd_verdict u_verdict (
    .kind(b_kind), .hit(b_hit), .verdict(b_verdict)
  );

  // Flow control
  always_comb begin
    b_retire = b_valid && (!b_verdict.forward || out_ready);
    b_free   = !b_valid || b_retire;
    a_to_b   = a_valid && b_free;
    in_ready = !a_valid || b_free;
    in_take  = in_valid && in_ready;
  end

  // Lookup port
  always_comb begin
    lkp_req_valid = a_to_b && (a_kind == K_AWAY_PLAIN);
    lkp_req_mac   = a_q[MAC_W-1:0];
  end

  // Downstream and local outputs
  always_comb begin
    out_valid      = b_valid && b_verdict.forward;
    out_bcast      = b_q[TAG_B] | b_verdict.set_tag;
    out_src        = b_q[SRC_LO +: NODE_W];
    out_mac        = b_q[MAC_W-1:0];
    out_handle     = b_q[HDL_LO +: HANDLE_W];
    deliver_valid  = b_retire && b_verdict.deliver;
    deliver_src    = b_q[SRC_LO +: NODE_W];
    deliver_mac    = b_q[MAC_W-1:0];
    deliver_handle = b_q[HDL_LO +: HANDLE_W];
  end

endmodule

// File: rtl/ring_fwd_unit_chk.sv
module ring_fwd_unit_chk #(
  parameter int MAC_W    = 48,
  parameter int NODE_W   = 4,
  parameter int HANDLE_W = 8,
  parameter int NODE_ID  = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_bcast,
  input logic [NODE_W-1:0]   out_src,
  input logic [MAC_W-1:0]    out_mac,
  input logic [HANDLE_W-1:0] out_handle,
  input logic                deliver_valid,
  input logic [NODE_W-1:0]   deliver_src
);

  // R8: a stalled output keeps its descriptor
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mac) && $stable(out_src)
                                && $stable(out_handle) && $stable(out_bcast));

  // R8: input back-pressure only comes from a blocked output
  p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  // R1: only broadcast copies are both delivered and forwarded
  p_both_bcast_r1: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_valid && out_valid |-> out_bcast);

  // R5: a home-sourced descriptor never leaves untagged
  p_home_tagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_src == NODE_W'(NODE_ID) |-> out_bcast);

  // R6: a home-sourced descriptor is never delivered here
  p_no_home_deliver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_valid |-> deliver_src != NODE_W'(NODE_ID));

endmodule

bind ring_fwd_unit ring_fwd_unit_chk #(
  .MAC_W(MAC_W), .NODE_W(NODE_W), .HANDLE_W(HANDLE_W), .NODE_ID(NODE_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_bcast(out_bcast), .out_src(out_src),
  .out_mac(out_mac), .out_handle(out_handle), .deliver_valid(deliver_valid),
  .deliver_src(deliver_src)
);

// File: tb/ring_fwd_unit_bench.sv
`timescale 1ns/1ps
module ring_fwd_unit_bench;

  localparam int MAC_W = 48, NODE_W = 4, HANDLE_W = 8, NODE_ID = 3;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid, in_ready, in_bcast;
  logic [NODE_W-1:0]   in_src;
  logic [MAC_W-1:0]    in_mac;
  logic [HANDLE_W-1:0] in_handle;
  logic                out_valid, out_ready, out_bcast;
  logic [NODE_W-1:0]   out_src;
  logic [MAC_W-1:0]    out_mac;
  logic [HANDLE_W-1:0] out_handle;
  logic                deliver_valid;
  logic [NODE_W-1:0]   deliver_src;
  logic [MAC_W-1:0]    deliver_mac;
  logic [HANDLE_W-1:0] deliver_handle;
  logic                lkp_req_valid, lkp_hit;
  logic [MAC_W-1:0]    lkp_req_mac;

  int total = 0, bad = 0, lkp_cnt = 0, cyc = 0;
  logic [MAC_W-1:0] last_key;
  bit done = 0;

  always #2 clk = ~clk;

  ring_fwd_unit #(.MAC_W(MAC_W), .NODE_W(NODE_W), .HANDLE_W(HANDLE_W), .NODE_ID(NODE_ID))
  u_ring_fwd_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bcast(in_bcast), .in_src(in_src), .in_mac(in_mac), .in_handle(in_handle),
    .out_valid(out_valid), .out_ready(out_ready), .out_bcast(out_bcast),
    .out_src(out_src), .out_mac(out_mac), .out_handle(out_handle),
    .deliver_valid(deliver_valid), .deliver_src(deliver_src),
    .deliver_mac(deliver_mac), .deliver_handle(deliver_handle),
    .lkp_req_valid(lkp_req_valid), .lkp_req_mac(lkp_req_mac), .lkp_hit(lkp_hit)
  );

  // Table model: addresses with top byte AA are local; answer one cycle later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) lkp_hit <= 1'b0;
    else        lkp_hit <= lkp_req_valid && (lkp_req_mac[47:40] == 8'hAA);
  end

  always @(posedge clk) begin
    if (lkp_req_valid) begin
      lkp_cnt  <= lkp_cnt + 1;
      last_key <= lkp_req_mac;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      finish_run();
    end
  end

  // {bcast, src[3:0], mac[47:0], dlv, fwd, tag, lkp}
  localparam logic [56:0] VEC [8] = '{
    {1'b1, 4'd5,  48'hAA00_0000_0010, 1'b1, 1'b1, 1'b1, 1'b0},  // R1
    {1'b1, 4'd1,  48'h1100_0000_0020, 1'b1, 1'b1, 1'b1, 1'b0},  // R1
    {1'b0, 4'd5,  48'hAA00_0000_0001, 1'b1, 1'b0, 1'b0, 1'b1},  // R3
    {1'b0, 4'd0,  48'h2200_0000_0002, 1'b0, 1'b1, 1'b0, 1'b1},  // R4
    {1'b0, 4'd3,  48'hAA00_0000_0003, 1'b0, 1'b1, 1'b1, 1'b0},  // R5
    {1'b0, 4'd3,  48'h2200_0000_0004, 1'b0, 1'b1, 1'b1, 1'b0},  // R5
    {1'b1, 4'd3,  48'h3300_0000_0005, 1'b0, 1'b0, 1'b0, 1'b0},  // R6
    {1'b0, 4'd15, 48'hAA00_0000_00FF, 1'b1, 1'b0, 1'b0, 1'b1}   // R3
  };

  initial begin
    rst_n = 1'b0; in_valid = 0; in_bcast = 0; in_src = '0; in_mac = '0;
    in_handle = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "in_ready", in_ready, 1);
    chk("R9", "out_valid", out_valid, 0);
    chk("R9", "deliver_valid", deliver_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "out_valid after release", out_valid, 0);

    for (int i = 0; i < 8; i++) begin
      logic [56:0] v;
      int          cnt0;
      v = VEC[i];
      cnt0 = lkp_cnt;
      @(negedge clk);
      in_valid = 1; in_bcast = v[56]; in_src = v[55:52]; in_mac = v[51:4];
      in_handle = HANDLE_W'(8'h10 + i);
      @(posedge clk);
      @(negedge clk);
      in_valid = 0;
      // R7: nothing visible one cycle after acceptance
      chk("R7", "early out_valid", out_valid, 0);
      chk("R7", "early deliver", deliver_valid, 0);
      @(negedge clk);
      chk(v[3] ? "R1/R3" : "R4/R5/R6", "deliver", deliver_valid, v[3]);
      chk(v[2] ? "R4/R5" : "R3/R6", "forward", out_valid, v[2]);
      if (v[2]) begin
        chk(v[1] ? "R5" : "R4", "out tag", out_bcast, v[1]);
        chk("R4", "out mac", out_mac, v[51:4]);
        chk("R4", "out src", out_src, v[55:52]);
        chk("R4", "out handle", out_handle, 8'h10 + i);
      end
      if (v[3]) chk("R1", "deliver handle", deliver_handle, 8'h10 + i);
      chk("R2", "lookup count", lkp_cnt - cnt0, v[0]);
      if (v[0]) chk("R2", "lookup key", last_key, v[51:4]);
      @(negedge clk);
      chk("R7", "drained", out_valid | deliver_valid, 0);
    end

    // R8: stall with a second descriptor queued
    out_ready = 0;
    in_valid = 1; in_bcast = 1; in_src = 4'd5; in_mac = 48'h4400_0000_0041; in_handle = 8'h41;
    @(posedge clk); @(negedge clk);
    in_bcast = 0; in_src = 4'd0; in_mac = 48'h5500_0000_0042; in_handle = 8'h42;
    chk("R8", "in_ready with room", in_ready, 1);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk("R8", "stalled out_valid", out_valid, 1);
    chk("R8", "stalled handle", out_handle, 8'h41);
    chk("R8", "no deliver while stalled", deliver_valid, 0);
    chk("R8", "in_ready low when full", in_ready, 0);
    repeat (3) @(negedge clk);
    chk("R8", "held handle", out_handle, 8'h41);
    chk("R8", "held tag", out_bcast, 1);
    out_ready = 1;
    #0.1;
    chk("R1", "deliver on release", deliver_valid, 1);
    @(negedge clk);
    chk("R8", "second in order", out_handle, 8'h42);
    chk("R4", "second untagged", out_bcast, 0);
    chk("R4", "second not delivered", deliver_valid, 0);
    @(negedge clk);
    chk("R8", "empty after drain", out_valid, 0);
    chk("R8", "ready after drain", in_ready, 1);

    finish_run();
  end

endmodule